// File: doc/BRIEF.md
# Flash Write-Suspend Command Controller

This block is the suspend and resume control inside a serial flash device. Command bytes arrive as pairs of 4-bit nibbles, high nibble first, while an active-low chip select is held low. When a complete two-nibble frame carrying the suspend opcode (0xB0) closes during a running sector erase, block erase or page program, the block freezes that operation. It sets the matching suspend status bit and holds write-in-progress high for a fixed readiness latency. The latency is derived from a clock-frequency parameter and defaults to 20 us.

Program, erase and read requests reach the block as an already decoded operation and address. While an erase is suspended, a program may run in any sector other than the frozen one. While a program is suspended, an erase may run on any region that does not cover the frozen page. Requests aimed at the frozen region are refused. Reads of the frozen region are accepted but flagged as returning unreliable data. A resume opcode continues the frozen operation from the busy count it had left. Busy times are modelled as simple down-counters.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: A frame counts only when chip select rises after exactly two nibbles; the byte is the first nibble in bits 7:4 and the second in bits 3:0. A frame of any other nibble count, or with another byte value, changes nothing.
- R2: A suspend frame (0xB0) that closes during a sector erase (op 2) or block erase (op 3) raises st_erase_susp and leaves st_prog_susp at 0.
- R3: A suspend frame that closes during a page program (op 1) raises st_prog_susp and leaves st_erase_susp at 0.
- R4: st_wip is 1 while an operation runs and for LAT_US*CLK_MHZ cycles after a suspend, then 0. A request presented while st_wip is 1 is answered with cmd_nak one cycle later.
- R5: With an erase suspended, a program whose address lies in the frozen sector (address bits above SECT_BITS) or block (above BLK_BITS) is refused with cmd_nak; a program elsewhere gets cmd_ack and runs for PROG_CYC cycles.
- R6: With a program suspended, an erase whose sector or block contains the frozen page gets cmd_nak; an erase of another region gets cmd_ack and runs.
- R7: A read (op 0) while suspended gets cmd_ack, and rd_invalid is 1 in the same cycle as cmd_ack exactly when the address lies in the frozen page, sector or block.
- R8: A suspend frame while idle or while already suspended changes no status bit.
- R9: A resume frame (RES_OP, default 0x30) when suspended and st_wip is 0 clears the suspend bit and sets st_wip. The operation then ends once its remaining busy count has run out, so its total busy time equals its full length.
- R10: A request of the same kind as the suspended operation (an erase while an erase is suspended, a program while a program is suspended) is refused with cmd_nak.
- R11: After reset all status and response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing a command |
| nib_stb | input | 1 | A nibble is present on nib this cycle |
| nib | input | 4 | Command nibble |
| cmd_valid | input | 1 | Decoded request present for one cycle |
| cmd_op | input | 2 | 0 read, 1 page program, 2 sector erase, 3 block erase |
| cmd_addr | input | AW | Request byte address |
| cmd_ack | output | 1 | Previous-cycle request accepted |
| cmd_nak | output | 1 | Previous-cycle request refused |
| rd_invalid | output | 1 | Accepted read targets the frozen region |
| st_erase_susp | output | 1 | Erase suspended status |
| st_prog_susp | output | 1 | Program suspended status |
| st_wip | output | 1 | Write or latency in progress |

## Verification
A wrong internal state shows at the ports within a cycle or two. A badly counted nibble or a missed chip-select edge leaves a status bit unchanged two cycles after the frame closes. A wrong frozen address or granularity flips cmd_ack against cmd_nak, or changes rd_invalid, on the cycle after the request. A corrupted latency or remaining busy count moves the cycle in which st_wip falls. The bench model predicts that cycle exactly and compares every output on every clock.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_ESUSP,
        ST_PSUSP
    } fsc_state_e;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_PROG   = 2'd1;
    localparam logic [1:0] OP_SERASE = 2'd2;
    localparam logic [1:0] OP_BERASE = 2'd3;

endpackage

// File: rtl/fsc_nibble_rx.sv
// Collects two-nibble frames between chip-select edges; pulses an event
// for a valid suspend or resume byte one cycle after chip select rises.
module fsc_nibble_rx #(
    parameter logic [7:0] SUS_OP = 8'hB0,
    parameter logic [7:0] RES_OP = 8'h30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       nib_stb,
    input  logic [3:0] nib,
    output logic       sus_evt,
    output logic       res_evt
);

    typedef struct packed {
        logic       cs;
        logic [1:0] cnt;
        logic [7:0] sh;
        logic       sus;
        logic       res;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.sus = 1'b0;
        rx_d.res = 1'b0;
        rx_d.cs  = cs_n;
        if (!cs_n) begin
            if (nib_stb) begin
                rx_d.sh = {rx_q.sh[3:0], nib};
                if (rx_q.cnt != 2'd3) rx_d.cnt = rx_q.cnt + 2'd1;
            end
        end else begin
            rx_d.cnt = 2'd0;
            if (!rx_q.cs && rx_q.cnt == 2'd2) begin
                rx_d.sus = (rx_q.sh == SUS_OP);
                rx_d.res = (rx_q.sh == RES_OP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.cs <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sus_evt = rx_q.sus;
    assign res_evt = rx_q.res;

endmodule

// File: rtl/fsc_downcnt.sv
// Loadable down-counter that stops at zero and can be frozen.
module fsc_downcnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          hold,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                       cnt_d = load_val;
        else if (!hold && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/fsc_region.sv
// Same-region test at the coarser of two granularities.
module fsc_region #(
    parameter int AW = 24,
    parameter int SW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] frz_addr,
    input  logic [SW-1:0] cmd_bits,
    input  logic [SW-1:0] frz_bits,
    output logic          hit
);

    logic [SW-1:0] sh;

    always_comb begin
        sh  = (cmd_bits > frz_bits) ? cmd_bits : frz_bits;
        hit = ((addr >> sh) == (frz_addr >> sh));
    end

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
    import fsc_pkg::*;
#(
    parameter int         AW        = 24,
    parameter int         PAGE_BITS = 8,
    parameter int         SECT_BITS = 12,
    parameter int         BLK_BITS  = 16,
    parameter int         PROG_CYC  = 40,
    parameter int         ERASE_CYC = 120,
    parameter int         BLK_CYC   = 200,
    parameter int         CLK_MHZ   = 100,
    parameter int         LAT_US    = 20,
    parameter logic [7:0] SUS_OP    = 8'hB0,
    parameter logic [7:0] RES_OP    = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          nib_stb,
    input  logic [3:0]    nib,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    output logic          cmd_ack,
    output logic          cmd_nak,
    output logic          rd_invalid,
    output logic          st_erase_susp,
    output logic          st_prog_susp,
    output logic          st_wip
);

    localparam int LAT_CYC = CLK_MHZ * LAT_US;
    localparam int MAXC_A  = (LAT_CYC > BLK_CYC) ? LAT_CYC : BLK_CYC;
    localparam int MAXC    = (MAXC_A > ERASE_CYC) ? MAXC_A : ERASE_CYC;
    localparam int CW      = $clog2(MAXC + 1);
    localparam int SW      = $clog2(AW + 1);

    typedef struct packed {
        fsc_state_e    st;
        logic [AW-1:0] fa;
        logic [SW-1:0] fb;
        logic          ack;
        logic          nak;
        logic          rdi;
    } core_t;

    core_t c_d, c_q;

    logic          sus_evt, res_evt;
    logic [CW-1:0] run_cnt, nest_cnt, lat_cnt;
    logic          run_load, nest_load, lat_load, run_hold;
    logic [CW-1:0] run_val, nest_val, op_cyc;
    logic [SW-1:0] op_bits;
    logic          hit, in_run, in_susp, wip, ready;

    fsc_nibble_rx #(.SUS_OP(SUS_OP), .RES_OP(RES_OP)) i_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .nib_stb(nib_stb), .nib(nib),
        .sus_evt(sus_evt), .res_evt(res_evt)
    );

    fsc_downcnt #(.CW(CW)) i_run (
        .clk(clk), .rst_n(rst_n), .load(run_load), .load_val(run_val),
        .hold(run_hold), .cnt(run_cnt)
    );

    fsc_downcnt #(.CW(CW)) i_nest (
        .clk(clk), .rst_n(rst_n), .load(nest_load), .load_val(nest_val),
        .hold(1'b0), .cnt(nest_cnt)
    );

    fsc_downcnt #(.CW(CW)) i_lat (
        .clk(clk), .rst_n(rst_n), .load(lat_load), .load_val(CW'(LAT_CYC)),
        .hold(1'b0), .cnt(lat_cnt)
    );

    fsc_region #(.AW(AW), .SW(SW)) i_reg (
        .addr(cmd_addr), .frz_addr(c_q.fa), .cmd_bits(op_bits),
        .frz_bits(c_q.fb), .hit(hit)
    );

    always_comb begin
        case (cmd_op)
            OP_PROG:   begin op_bits = SW'(PAGE_BITS); op_cyc = CW'(PROG_CYC);  end
            OP_SERASE: begin op_bits = SW'(SECT_BITS); op_cyc = CW'(ERASE_CYC); end
            OP_BERASE: begin op_bits = SW'(BLK_BITS);  op_cyc = CW'(BLK_CYC);   end
            default:   begin op_bits = '0;             op_cyc = '0;             end
        endcase
    end

    assign in_run   = (c_q.st == ST_ERASE) || (c_q.st == ST_PROG);
    assign in_susp  = (c_q.st == ST_ESUSP) || (c_q.st == ST_PSUSP);
    assign wip      = in_run || (nest_cnt != '0) || (lat_cnt != '0);
    assign ready    = !wip && !res_evt;
    assign run_hold = !in_run || sus_evt;

    always_comb begin
        c_d       = c_q;
        c_d.ack   = 1'b0;
        c_d.nak   = 1'b0;
        c_d.rdi   = 1'b0;
        run_load  = 1'b0;
        run_val   = op_cyc;
        nest_load = 1'b0;
        nest_val  = op_cyc;
        lat_load  = 1'b0;

        // operation progress, suspend and resume
        case (c_q.st)
            ST_ERASE, ST_PROG: begin
                if (sus_evt) begin
                    c_d.st   = (c_q.st == ST_ERASE) ? ST_ESUSP : ST_PSUSP;
                    lat_load = 1'b1;
                end else if (run_cnt == CW'(1)) begin
                    c_d.st = ST_IDLE;
                end
            end
            ST_ESUSP: if (res_evt && !wip) c_d.st = ST_ERASE;
            ST_PSUSP: if (res_evt && !wip) c_d.st = ST_PROG;
            default: ;
        endcase

        // decoded requests
        if (cmd_valid) begin
            if (!ready) begin
                c_d.nak = 1'b1;
            end else if (cmd_op == OP_READ) begin
                c_d.ack = 1'b1;
                c_d.rdi = in_susp && hit;
            end else if (c_q.st == ST_IDLE) begin
                c_d.ack  = 1'b1;
                c_d.st   = (cmd_op == OP_PROG) ? ST_PROG : ST_ERASE;
                c_d.fa   = cmd_addr;
                c_d.fb   = op_bits;
                run_load = 1'b1;
            end else begin
                // suspended: opposite kind only, outside the frozen region
                if (hit || ((cmd_op == OP_PROG) == (c_q.st == ST_PSUSP))) begin
                    c_d.nak = 1'b1;
                end else begin
                    c_d.ack   = 1'b1;
                    nest_load = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign cmd_ack       = c_q.ack;
    assign cmd_nak       = c_q.nak;
    assign rd_invalid    = c_q.rdi;
    assign st_erase_susp = (c_q.st == ST_ESUSP);
    assign st_prog_susp  = (c_q.st == ST_PSUSP);
    assign st_wip        = wip;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ack,
    input logic cmd_nak,
    input logic rd_invalid,
    input logic st_erase_susp,
    input logic st_prog_susp,
    input logic st_wip
);

    a_r2_erase_susp_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_erase_susp) |-> $past(st_wip));

    a_r3_prog_susp_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_prog_susp) |-> $past(st_wip));

    a_r4_wip_after_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_erase_susp) || $rose(st_prog_susp)) |-> st_wip);

    a_r4_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid) && $past(st_wip)) |-> cmd_nak);

    a_r4_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ack, cmd_nak}));

    a_r7_invalid_only_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |-> (cmd_ack && (st_erase_susp || st_prog_susp)));

    a_r8_single_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_erase_susp, st_prog_susp}));

    a_r9_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_erase_susp) || $fell(st_prog_susp)) |-> st_wip);

endmodule

bind flash_suspend_ctrl fsc_checker i_fsc_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ack(cmd_ack),
    .cmd_nak(cmd_nak), .rd_invalid(rd_invalid), .st_erase_susp(st_erase_susp),
    .st_prog_susp(st_prog_susp), .st_wip(st_wip)
);

// File: tb/test_flash_suspend_ctrl.sv
module test_flash_suspend_ctrl;

    localparam int LAT = 2000;
    localparam int PCY = 40;
    localparam int ECY = 120;
    localparam int BCY = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        nib_stb = 1'b0;
    logic [3:0]  nib = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic        cmd_ack, cmd_nak, rd_invalid, st_erase_susp, st_prog_susp, st_wip;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    flash_suspend_ctrl i_flash_suspend_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .nib_stb(nib_stb), .nib(nib),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ack(cmd_ack), .cmd_nak(cmd_nak), .rd_invalid(rd_invalid),
        .st_erase_susp(st_erase_susp), .st_prog_susp(st_prog_susp), .st_wip(st_wip)
    );

    // ---------------- behavioural reference model ----------------
    // m_st: 0 idle, 1 erasing, 2 programming, 3 erase suspended, 4 program suspended
    int m_st, m_run, m_nest, m_lat, m_fa, m_fb, m_nc, m_sh;
    bit m_csq, m_sus, m_res, m_ack, m_nak, m_rdi;

    function automatic bit m_wip();
        return (m_st == 1 || m_st == 2 || m_nest > 0 || m_lat > 0);
    endfunction

    function automatic bit m_hit(int a, int cb);
        int s;
        s = (cb > m_fb) ? cb : m_fb;
        return ((a >> s) == (m_fa >> s));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_nest = 0; m_lat = 0; m_fa = 0; m_fb = 0;
            m_nc = 0; m_sh = 0; m_csq = 1; m_sus = 0; m_res = 0;
            m_ack = 0; m_nak = 0; m_rdi = 0;
        end else begin
            bit n_sus, n_res, w, a, k, r;
            int nst, nrun, nnest, nlat, nfa, nfb, cb, cy;
            n_sus = 0; n_res = 0;
            if (!cs_n) begin
                if (nib_stb) begin
                    m_sh = ((m_sh << 4) | int'(nib)) & 255;
                    if (m_nc < 3) m_nc++;
                end
            end else begin
                if (!m_csq && m_nc == 2) begin
                    n_sus = (m_sh == 8'hB0);
                    n_res = (m_sh == 8'h30);
                end
                m_nc = 0;
            end
            m_csq = cs_n;

            w = m_wip();
            nst = m_st; nfa = m_fa; nfb = m_fb;
            nrun  = ((m_st == 1 || m_st == 2) && !m_sus && m_run > 0) ? m_run - 1 : m_run;
            nnest = (m_nest > 0) ? m_nest - 1 : 0;
            nlat  = (m_lat > 0) ? m_lat - 1 : 0;
            if (m_st == 1 || m_st == 2) begin
                if (m_sus) begin nst = m_st + 2; nlat = LAT; end
                else if (m_run == 1) nst = 0;
            end else if (m_st >= 3) begin
                if (m_res && !w) nst = m_st - 2;
            end
            a = 0; k = 0; r = 0;
            if (cmd_valid) begin
                cb = (cmd_op == 1) ? 8 : (cmd_op == 2) ? 12 : (cmd_op == 3) ? 16 : 0;
                cy = (cmd_op == 1) ? PCY : (cmd_op == 2) ? ECY : BCY;
                if (w || m_res) k = 1;
                else if (cmd_op == 0) begin a = 1; r = (m_st >= 3) && m_hit(int'(cmd_addr), 0); end
                else if (m_st == 0) begin
                    a = 1; nst = (cmd_op == 1) ? 2 : 1; nrun = cy; nfa = int'(cmd_addr); nfb = cb;
                end else if (m_hit(int'(cmd_addr), cb) || ((cmd_op == 1) == (m_st == 4))) k = 1;
                else begin a = 1; nnest = cy; end
            end
            m_st = nst; m_run = nrun; m_nest = nnest; m_lat = nlat; m_fa = nfa; m_fb = nfb;
            m_ack = a; m_nak = k; m_rdi = r; m_sus = n_sus; m_res = n_res;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 erase-suspend bit", st_erase_susp, m_st == 3);
            chk("R3 program-suspend bit", st_prog_susp, m_st == 4);
            chk("R4 write-in-progress", st_wip, m_wip());
            chk("R5 acknowledge", cmd_ack, m_ack);
            chk("R6 refuse", cmd_nak, m_nak);
            chk("R7 read invalid", rd_invalid, m_rdi);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic frame(input logic [7:0] b, input int n);
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nib_stb = 1'b1;
            nib = (i % 2 == 0) ? b[7:4] : b[3:0];
        end
        @(negedge clk);
        nib_stb = 1'b0;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic req(input logic [1:0] op, input logic [23:0] adr,
                       output bit ak, output bit nk, output bit ri);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = adr;
        @(negedge clk);
        cmd_valid = 1'b0;
        ak = cmd_ack; nk = cmd_nak; ri = rd_invalid;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (st_wip && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ak, nk, ri;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {cmd_ack, cmd_nak, rd_invalid, st_erase_susp, st_prog_susp, st_wip}, 0);

        // R8 suspend while idle
        frame(8'hB0, 2);
        chk("R8 idle suspend ignored", {st_erase_susp, st_prog_susp, st_wip}, 0);

        // sector erase, then suspend
        req(2'd2, 24'h012345, ak, nk, ri);
        chk("R2 erase accepted", ak, 1);
        repeat (5) @(negedge clk);
        frame(8'hB0, 2);
        chk("R2 erase suspended", st_erase_susp, 1);
        chk("R2 program bit clear", st_prog_susp, 0);
        req(2'd1, 24'h400000, ak, nk, ri);
        chk("R4 refused during latency", nk, 1);
        wait_ready(n);
        chk("R4 latency length", (n > LAT - 20 && n <= LAT) ? 1 : 0, 1);

        // R5 region guard, R10 same kind, R7 reads
        req(2'd1, 24'h012800, ak, nk, ri);
        chk("R5 program in frozen sector", nk, 1);
        req(2'd3, 24'h500000, ak, nk, ri);
        chk("R10 erase while erase suspended", nk, 1);
        req(2'd0, 24'h0123AB, ak, nk, ri);
        chk("R7 read frozen sector ack", ak, 1);
        chk("R7 read frozen sector invalid", ri, 1);
        req(2'd0, 24'h050000, ak, nk, ri);
        chk("R7 read elsewhere valid", ri, 0);
        req(2'd1, 24'h020000, ak, nk, ri);
        chk("R5 program elsewhere", ak, 1);
        wait_ready(n);
        chk("R5 nested program length", (n > PCY - 5 && n <= PCY) ? 1 : 0, 1);

        // R8 suspend while suspended, R1 bad frames
        frame(8'hB0, 2);
        chk("R8 repeat suspend ignored", {st_erase_susp, st_wip}, 2);
        frame(8'h30, 3);
        chk("R1 three-nibble resume dropped", {st_erase_susp, st_wip}, 2);
        frame(8'h31, 2);
        chk("R1 other byte dropped", {st_erase_susp, st_wip}, 2);
        frame(8'h30, 2);
        chk("R9 resume clears bit", st_erase_susp, 0);
        chk("R9 resume busy", st_wip, 1);
        wait_ready(n);
        chk("R9 remaining erase time", (n > ECY - 30 && n < ECY - 5) ? 1 : 0, 1);

        // program, suspended
        req(2'd1, 24'h100000, ak, nk, ri);
        repeat (8) @(negedge clk);
        frame(8'hB0, 2);
        chk("R3 program suspended", st_prog_susp, 1);
        chk("R3 erase bit clear", st_erase_susp, 0);
        wait_ready(n);
        req(2'd2, 24'h100000, ak, nk, ri);
        chk("R6 erase sector over page", nk, 1);
        req(2'd3, 24'h10F000, ak, nk, ri);
        chk("R6 erase block over page", nk, 1);
        req(2'd1, 24'h700000, ak, nk, ri);
        chk("R10 program while program suspended", nk, 1);
        req(2'd0, 24'h100055, ak, nk, ri);
        chk("R7 read frozen page", ri, 1);
        req(2'd0, 24'h100155, ak, nk, ri);
        chk("R7 read neighbour page", ri, 0);
        req(2'd2, 24'h200000, ak, nk, ri);
        chk("R6 erase elsewhere", ak, 1);
        wait_ready(n);
        frame(8'h30, 2);
        chk("R9 program resumed", {st_prog_susp, st_wip}, 1);
        wait_ready(n);

        // block erase; short frame ignored, then proper suspend
        req(2'd3, 24'h300000, ak, nk, ri);
        frame(8'hB0, 1);
        chk("R1 one-nibble suspend dropped", {st_erase_susp, st_wip}, 1);
        frame(8'hB0, 2);
        chk("R2 block erase suspended", st_erase_susp, 1);
        wait_ready(n);
        req(2'd1, 24'h30F000, ak, nk, ri);
        chk("R5 program in frozen block", nk, 1);
        frame(8'h30, 2);
        wait_ready(n);
        chk("R9 block erase finished", {st_erase_susp, st_wip}, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule